// File: doc/BRIEF.md
# Tag-Matched Two-Level Multicast Bus

This block carries words from one ready/valid master to a grid of slaves, for example the processing elements of a compute array. Each word travels with two tags: a row tag and a column tag. Every row of the grid has a row ID, and every slave has a column ID. A word goes to every slave whose row ID equals the row tag and whose column ID equals the column tag. A single word can therefore reach one slave, a whole row, a whole column or any pattern the IDs allow, all in the same transfer.

The master sees its word accepted only when every targeted slave accepts it in the same cycle. A word whose tags match no slave is accepted at once and dropped.

IDs are programmed through two serial scan chains, one for row IDs and one for column IDs. Each chain shifts one stage per clock while its load strobe is high. A small controller blocks all traffic while either chain is loading. The controller has two states:
- `ST_SCAN` is entered from `ST_RUN` in any cycle in which a strobe is high. It stays in `ST_SCAN` while a strobe is high.
- It returns to `ST_RUN` after the first cycle in which both strobes are low. That cycle is a settle cycle, and delivery is still blocked during it.

Top module: `mc_net`

## Requirements
- R1: After reset, every row ID and every column ID is zero, so row tag 0 with column tag 0 reaches every slave.
- R2: While `set_y` is high, each clock shifts the row chain: row 0 takes `y_scan_in` and row r takes the old ID of row r-1. While `set_x` is high, the column chain shifts in the same way over the slave index i = r*COLS + c, with slave 0 taking `x_scan_in`. The two chains shift independently, and IDs hold while their strobe is low.
- R3: `s_valid[i]` is high exactly when `m_valid` is high, delivery is enabled, the ID of row r equals `tag_y`, and the ID of slave i equals `tag_x`.
- R4: `s_data` always carries `m_data` to all slaves.
- R5: When delivery is enabled, `m_ready` is the AND of `s_ready` over the targeted slaves. One targeted slave that is not ready stalls the master.
- R6: When no slave matches the tags and delivery is enabled, `m_ready` is high, so the word is consumed and dropped.
- R7: In any cycle in which `set_x` or `set_y` is high, `s_valid` is all zero and `m_ready` is low.
- R8: In the first cycle after both strobes fall (the settle cycle in `ST_SCAN`), `s_valid` is still all zero and `m_ready` is still low. Delivery resumes on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_x | input | 1 | Shift strobe for the column-ID chain |
| x_scan_in | input | XW | Serial input to the column-ID chain |
| set_y | input | 1 | Shift strobe for the row-ID chain |
| y_scan_in | input | YW | Serial input to the row-ID chain |
| tag_x | input | XW | Column tag of the current word |
| tag_y | input | YW | Row tag of the current word |
| m_valid | input | 1 | Master word valid |
| m_ready | output | 1 | Master word accepted |
| m_data | input | DW | Master word |
| s_ready | input | ROWS*COLS | Per-slave ready |
| s_valid | output | ROWS*COLS | Per-slave valid |
| s_data | output | DW | Word shared by all slaves |

## Verification
The hardest case to reach from the ports is a stall that comes only from the AND across several matched slaves. Reaching it needs IDs in which more than one row and more than one column share a value. The bench therefore shifts a pattern with repeated IDs into both chains. It then clears one `s_ready` bit at a time while presenting a multicast tag, so that the one matched slave that is not ready must hold off the master, and an unmatched slave that is not ready must not. A full sweep of both tags after loading checks each shifted ID through the `s_valid` pattern it produces. A further one-stage shift of both chains together checks that they move independently of each other.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SCAN = 1'b1
    } net_state_t;

endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl #(
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_id,
    input  logic [IDW-1:0] id_in,
    output logic [IDW-1:0] id_out,
    input  logic [IDW-1:0] tag,
    input  logic           valid_in,
    output logic           valid_out,
    input  logic           ready_in,
    output logic           ready_out
);

    logic [IDW-1:0] id_q;
    logic           hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            id_q <= '0;
        else if (set_id)
            id_q <= id_in;
    end

    // The old ID leaves on the same edge that the next stage samples it.
    assign id_out    = id_q;
    assign hit       = (id_q == tag);
    assign valid_out = valid_in & hit;
    assign ready_out = hit ? ready_in : 1'b1;

endmodule

// File: rtl/mc_bus.sv
module mc_bus #(
    parameter int NS  = 4,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_id,
    input  logic [IDW-1:0] scan_in,
    output logic [IDW-1:0] scan_out,
    input  logic [IDW-1:0] tag,
    input  logic           master_valid,
    output logic           master_ready,
    input  logic [NS-1:0]  slave_ready,
    output logic [NS-1:0]  slave_valid
);

    logic [IDW-1:0] chain [NS+1];
    logic [NS-1:0]  rdy_each;

    assign chain[0] = scan_in;

    for (genvar k = 0; k < NS; k++) begin : g_port
        mc_ctrl #(.IDW(IDW)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_id    (set_id),
            .id_in     (chain[k]),
            .id_out    (chain[k+1]),
            .tag       (tag),
            .valid_in  (master_valid),
            .valid_out (slave_valid[k]),
            .ready_in  (slave_ready[k]),
            .ready_out (rdy_each[k])
        );
    end

    assign scan_out     = chain[NS];
    assign master_ready = &rdy_each;

endmodule

// File: rtl/mc_net.sv
module mc_net #(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    parameter int XW   = 3,
    parameter int YW   = 2,
    parameter int DW   = 16,
    localparam int NSL = ROWS * COLS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_x,
    input  logic [XW-1:0]  x_scan_in,
    input  logic           set_y,
    input  logic [YW-1:0]  y_scan_in,
    input  logic [XW-1:0]  tag_x,
    input  logic [YW-1:0]  tag_y,
    input  logic           m_valid,
    output logic           m_ready,
    input  logic [DW-1:0]  m_data,
    input  logic [NSL-1:0] s_ready,
    output logic [NSL-1:0] s_valid,
    output logic [DW-1:0]  s_data
);
    import mc_pkg::*;

    net_state_t state_q, state_d;
    logic       any_set;
    logic       fwd_en;
    logic       row_mready;
    logic [ROWS-1:0] row_valid;
    logic [ROWS-1:0] row_ready;
    logic [YW-1:0]   y_tail;
    logic [XW-1:0]   x_link [ROWS+1];

    assign any_set = set_x | set_y;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (any_set)  state_d = ST_SCAN;
            ST_SCAN: if (!any_set) state_d = ST_RUN;
        endcase
    end

    // Outputs: delivery only in ST_RUN with both strobes low
    always_comb begin
        fwd_en = 1'b0;
        unique case (state_q)
            ST_RUN:  fwd_en = !any_set;
            ST_SCAN: fwd_en = 1'b0;
        endcase
    end

    mc_bus #(.NS(ROWS), .IDW(YW)) u_row_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_id       (set_y),
        .scan_in      (y_scan_in),
        .scan_out     (y_tail),
        .tag          (tag_y),
        .master_valid (m_valid & fwd_en),
        .master_ready (row_mready),
        .slave_ready  (row_ready),
        .slave_valid  (row_valid)
    );

    assign x_link[0] = x_scan_in;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        mc_bus #(.NS(COLS), .IDW(XW)) u_col_bus (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_id       (set_x),
            .scan_in      (x_link[r]),
            .scan_out     (x_link[r+1]),
            .tag          (tag_x),
            .master_valid (row_valid[r]),
            .master_ready (row_ready[r]),
            .slave_ready  (s_ready[r*COLS +: COLS]),
            .slave_valid  (s_valid[r*COLS +: COLS])
        );
    end

    assign m_ready = row_mready & fwd_en;
    assign s_data  = m_data;

    logic unused_tails;
    assign unused_tails = ^{y_tail, x_link[ROWS]};

endmodule

// File: rtl/mc_net_chk.sv
module mc_net_chk #(
    parameter int ROWS = 3,
    parameter int COLS = 4,
    parameter int XW   = 3,
    parameter int YW   = 2,
    parameter int DW   = 16,
    localparam int NSL = ROWS * COLS
) (
    input logic           clk,
    input logic           rst_n,
    input logic           set_x,
    input logic           set_y,
    input logic           m_valid,
    input logic           m_ready,
    input logic [NSL-1:0] s_ready,
    input logic [NSL-1:0] s_valid
);

    a_r7_scan_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_x || set_y) |-> (!m_ready && s_valid == '0));

    a_r8_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_x || set_y) |-> (!m_ready && s_valid == '0));

    a_r3_valid_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid != '0) |-> m_valid);

    a_r5_ack_all_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |-> ((s_valid & ~s_ready) == '0));

    a_r5_stall_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && ((s_valid & ~s_ready) != '0)) |-> !m_ready);

    a_r6_drop_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !set_x && !set_y && !$past(set_x || set_y) && s_valid == '0)
        |-> m_ready);

endmodule

bind mc_net mc_net_chk #(
    .ROWS(ROWS), .COLS(COLS), .XW(XW), .YW(YW), .DW(DW)
) u_mc_net_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_x   (set_x),
    .set_y   (set_y),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .s_ready (s_ready),
    .s_valid (s_valid)
);

// File: tb/test_mc_net.sv
module test_mc_net;
    localparam int ROWS = 3;
    localparam int COLS = 4;
    localparam int XW   = 3;
    localparam int YW   = 2;
    localparam int DW   = 16;
    localparam int NSL  = ROWS * COLS;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           set_x, set_y;
    logic [XW-1:0]  x_scan_in, tag_x;
    logic [YW-1:0]  y_scan_in, tag_y;
    logic           m_valid, m_ready;
    logic [DW-1:0]  m_data, s_data;
    logic [NSL-1:0] s_ready, s_valid;

    int errors = 0;
    int checks = 0;
    logic [YW-1:0] mdl_y [ROWS];
    logic [XW-1:0] mdl_x [NSL];

    always #5 clk = ~clk;

    mc_net #(.ROWS(ROWS), .COLS(COLS), .XW(XW), .YW(YW), .DW(DW)) i_mc_net (
        .clk(clk), .rst_n(rst_n), .set_x(set_x), .x_scan_in(x_scan_in),
        .set_y(set_y), .y_scan_in(y_scan_in), .tag_x(tag_x), .tag_y(tag_y),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .s_ready(s_ready), .s_valid(s_valid), .s_data(s_data)
    );

    task automatic check_bits(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one word and compare against the model (inputs driven after negedge).
    task automatic probe(string req, logic [XW-1:0] tx, logic [YW-1:0] ty,
                         logic mv, logic [NSL-1:0] rdy, logic blocked);
        logic [NSL-1:0] ev;
        logic           er;
        @(negedge clk);
        tag_x = tx; tag_y = ty; m_valid = mv; s_ready = rdy;
        m_data = DW'(16'hA500 ^ {tx, ty});
        #1;
        er = !blocked;
        for (int i = 0; i < NSL; i++) begin
            ev[i] = mv && !blocked && (mdl_y[i / COLS] == ty) && (mdl_x[i] == tx);
            if (ev[i] && !rdy[i]) er = 1'b0;
        end
        check_bits(req, 64'(s_valid), 64'(ev));
        if (mv) check_bits(req, 64'(m_ready), 64'(er));
        check_bits("R4", 64'(s_data), 64'(m_data));
    endtask

    // One shift clock on either or both chains; R7 checked during it.
    task automatic shift(logic sx, logic [XW-1:0] xv, logic sy, logic [YW-1:0] yv);
        @(negedge clk);
        set_x = sx; x_scan_in = xv; set_y = sy; y_scan_in = yv;
        m_valid = 1'b1; s_ready = '1; tag_x = '0; tag_y = '0;
        #1;
        check_bits("R7", 64'({m_ready, s_valid}), 64'(0));
        @(posedge clk);
        if (sy) begin
            for (int r = ROWS - 1; r > 0; r--) mdl_y[r] = mdl_y[r-1];
            mdl_y[0] = yv;
        end
        if (sx) begin
            for (int i = NSL - 1; i > 0; i--) mdl_x[i] = mdl_x[i-1];
            mdl_x[0] = xv;
        end
    endtask

    task automatic release_scan();
        @(negedge clk);
        set_x = 1'b0; set_y = 1'b0;
        #1;
        check_bits("R8", 64'({m_ready, s_valid}), 64'(0));
    endtask

    task automatic t_reset();
        set_x = 0; set_y = 0; x_scan_in = 0; y_scan_in = 0;
        tag_x = 0; tag_y = 0; m_valid = 0; m_data = 0; s_ready = '1;
        rst_n = 1'b0;
        for (int r = 0; r < ROWS; r++) mdl_y[r] = '0;
        for (int i = 0; i < NSL; i++) mdl_x[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        probe("R1", 0, 0, 1'b1, '1, 1'b0);
        check_bits("R1", 64'(s_valid), 64'({NSL{1'b1}}));
        probe("R3", 0, 0, 1'b0, '1, 1'b0);
    endtask

    task automatic t_load_and_sweep();
        for (int k = 0; k < NSL; k++) begin
            shift(1'b1, XW'((k * 5 + 1) % 8), (k < ROWS), YW'((k == 1) ? 1 : 2));
        end
        release_scan();
        for (int ty = 0; ty < 4; ty++)
            for (int tx = 0; tx < 8; tx++)
                probe("R2", XW'(tx), YW'(ty), 1'b1, '1, 1'b0);
    endtask

    task automatic t_stall();
        // multicast tag (row 2, column 6): each single not-ready slave in turn
        for (int j = 0; j < NSL; j++)
            probe("R5", 3'd6, 2'd2, 1'b1, ~(NSL'(1) << j), 1'b0);
        probe("R5", 3'd1, 2'd2, 1'b1, '0, 1'b0);
    endtask

    task automatic t_drop();
        probe("R6", 3'd2, 2'd3, 1'b1, '0, 1'b0);
        check_bits("R6", 64'(m_ready), 64'(1));
        probe("R6", 3'd2, 2'd1, 1'b1, '0, 1'b0);
    endtask

    task automatic t_joint_shift();
        shift(1'b1, 3'd7, 1'b1, 2'd3);
        shift(1'b0, 3'd0, 1'b1, 2'd0);
        release_scan();
        probe("R8", 3'd7, 2'd0, 1'b1, '1, 1'b0);
        for (int tx = 0; tx < 8; tx++) begin
            probe("R2", XW'(tx), 2'd3, 1'b1, '1, 1'b0);
            probe("R3", XW'(tx), 2'd2, 1'b1, '1, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_load_and_sweep();
        t_stall();
        t_drop();
        t_joint_shift();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule